// File: doc/BRIEF.md
# Differencing Commit Compressor with Sequence Tags

This block shrinks the per-instruction verification traffic that a processor under test sends to a checking model. Runs of instruction commits are merged into one commit record. The record holds the commit count and the indices of the first and last commit it covers. It also holds the architectural state seen at the last commit, split into `NF` fields of `FW` bits. The state is sent as a differential: a change bitmap against the previous commit record sent, followed by only the changed field values.

Non-deterministic events, such as an external interrupt, do not break a merge window. Each one is forwarded at once as an event record. The event carries a sequence tag equal to the number of commits that came before it, so a receiver can put it back at the right point in the commit order. The receiver rebuilds the unchanged fields from its own copy of the previous commit record.

Commit indices are free-running `IDXW`-bit counters that wrap. Two input rules apply to the caller. `nde_valid` is never high on two cycles in a row. Windows must not close so often that more than `QDEPTH` closed records wait behind events.

Top module: `commit_diff_compressor`

## Requirements
- R1: After reset, and until a record is produced, `rec_valid` stays 0.
- R2: A commit record covers consecutive commits. A commit's index is the number of commits accepted before it since reset. `rec_first` is the index of the first commit in the window, `rec_last` is the index of the last one, and `rec_count` is the number of commits merged.
- R3: A window closes on the commit that brings its count to `MAX_MERGE` (default 32). The next commit opens a new window.
- R4: A `flush` cycle closes an open window. A commit in the same cycle is included in that window. A `flush` with no open window and no commit produces no record.
- R5: A commit record's state is the field vector of its last commit. Bit i of `rec_mask` is 1 exactly when field i (bits i*FW upward of `commit_fields`) differs from field i of the previous commit record sent. In the first commit record after reset, every mask bit is 1.
- R6: The changed field values are packed into `rec_data` in increasing field order. Slot 0 is bits [FW-1:0], then slot 1, and so on. The slots beyond the number of set mask bits are 0.
- R7: An event on `nde_valid` appears as a record with `rec_is_event`=1 on the clock edge that samples it. `rec_first` and `rec_last` both equal the number of commits accepted before that cycle, so a same-cycle commit counts after the event. `rec_evcode` carries the event code. An event neither closes nor alters the open window.
- R8: A commit record is output on the edge after the one on which its window closed. Event records take the output first. Commit records leave in closing order, each following the previous one's `rec_last`.
- R9: Cycles with no commit, no flush and no event leave the open window unchanged and produce no record.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| commit_valid | input | 1 | One instruction committed this cycle |
| commit_fields | input | NF*FW | State after the commit, field i at bits i*FW upward |
| flush | input | 1 | Close the open window now |
| nde_valid | input | 1 | Non-deterministic event this cycle |
| nde_code | input | EVW | Event code |
| rec_valid | output | 1 | Record valid this cycle |
| rec_is_event | output | 1 | 1: event record, 0: commit record |
| rec_first | output | IDXW | First commit index, or sequence tag of an event |
| rec_last | output | IDXW | Last commit index, or sequence tag of an event |
| rec_count | output | $clog2(MAX_MERGE+1) | Commits merged (0 for events) |
| rec_mask | output | NF | Changed-field bitmap |
| rec_data | output | NF*FW | Changed field values, packed from slot 0 |
| rec_evcode | output | EVW | Event code (0 for commit records) |

## Verification
The bench covers several edge cases:
- An event in the same cycle as the commit that closes a window. A design that ordered the two the wrong way would emit the commit record before the event, or would give the tag a count that includes that commit.
- A window that fills to exactly the maximum. A design with an off-by-one in the close test would produce a count of 31 or 33.
- A flush with no commit. A design that got this wrong would report a wrong `rec_last` or lose the state held from the window's last commit.
- A flush into an empty window, which must stay silent.
- The first record after reset, which must carry the full state.
- Records where a non-contiguous set of fields changed. A packer that kept slot positions, or left stale data in unused slots, would show it here.

// File: rtl/ccz_pkg.sv
package ccz_pkg;

  typedef enum logic [1:0] {
    OUT_NONE  = 2'd0,
    OUT_EVENT = 2'd1,
    OUT_QUEUE = 2'd2
  } out_sel_e;

endpackage

// File: rtl/ccz_window.sv
module ccz_window #(
  parameter int NF        = 4,
  parameter int FW        = 16,
  parameter int IDXW      = 16,
  parameter int MAX_MERGE = 32,
  localparam int CW       = $clog2(MAX_MERGE + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               commit_valid,
  input  logic [NF*FW-1:0]   commit_fields,
  input  logic               flush,
  output logic               close,
  output logic [IDXW-1:0]    cl_first,
  output logic [IDXW-1:0]    cl_last,
  output logic [CW-1:0]      cl_count,
  output logic [NF*FW-1:0]   cl_fields,
  output logic [IDXW-1:0]    cur_idx
);

  logic [CW-1:0]    cnt;
  logic [CW-1:0]    cnt_nx;
  logic [IDXW-1:0]  idx;
  logic [IDXW-1:0]  first_q;
  logic [NF*FW-1:0] last_q;

  assign cnt_nx  = cnt + CW'(commit_valid);
  assign cur_idx = idx;

  always_comb begin
    close     = (commit_valid && (cnt_nx == CW'(MAX_MERGE))) ||
                (flush && (cnt_nx != '0));
    cl_first  = (cnt == '0) ? idx : first_q;
    cl_last   = commit_valid ? idx : (idx - IDXW'(1));
    cl_count  = cnt_nx;
    cl_fields = commit_valid ? commit_fields : last_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      idx     <= '0;
      first_q <= '0;
      last_q  <= '0;
    end else begin
      idx <= idx + IDXW'(commit_valid);
      if (commit_valid) begin
        last_q <= commit_fields;
      end
      if (close) begin
        cnt <= '0;
      end else if (commit_valid) begin
        cnt <= cnt_nx;
        if (cnt == '0) begin
          first_q <= idx;
        end
      end
    end
  end

endmodule

// File: rtl/ccz_diff.sv
module ccz_diff #(
  parameter int NF = 4,
  parameter int FW = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             close,
  input  logic [NF*FW-1:0] new_fields,
  output logic [NF-1:0]    mask,
  output logic [NF*FW-1:0] packed_vals
);

  logic [NF*FW-1:0] ref_q;
  logic             ref_valid;

  for (genvar g = 0; g < NF; g++) begin : g_cmp
    assign mask[g] = !ref_valid ||
                     (new_fields[g*FW +: FW] != ref_q[g*FW +: FW]);
  end

  always_comb begin
    int slot;
    slot        = 0;
    packed_vals = '0;
    for (int i = 0; i < NF; i++) begin
      if (mask[i]) begin
        packed_vals[slot*FW +: FW] = new_fields[i*FW +: FW];
        slot = slot + 1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ref_q     <= '0;
      ref_valid <= 1'b0;
    end else if (close) begin
      ref_q     <= new_fields;
      ref_valid <= 1'b1;
    end
  end

endmodule

// File: rtl/ccz_queue.sv
module ccz_queue #(
  parameter int W     = 32,
  parameter int DEPTH = 4,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);

  logic [W-1:0] mem [DEPTH];
  logic [AW:0]  wr_ptr;
  logic [AW:0]  rd_ptr;

  assign empty = (wr_ptr == rd_ptr);
  assign full  = (wr_ptr[AW-1:0] == rd_ptr[AW-1:0]) && (wr_ptr[AW] != rd_ptr[AW]);
  assign dout  = mem[rd_ptr[AW-1:0]];

  always_ff @(posedge clk) begin
    if (push) begin
      mem[wr_ptr[AW-1:0]] <= din;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
    end else begin
      if (push) wr_ptr <= wr_ptr + 1'b1;
      if (pop)  rd_ptr <= rd_ptr + 1'b1;
    end
  end

endmodule

// File: rtl/commit_diff_compressor.sv
module commit_diff_compressor
  import ccz_pkg::*;
#(
  parameter int NF        = 4,
  parameter int FW        = 16,
  parameter int IDXW      = 16,
  parameter int EVW       = 8,
  parameter int MAX_MERGE = 32,
  parameter int QDEPTH    = 4,
  localparam int CW       = $clog2(MAX_MERGE + 1),
  localparam int EW       = 2*IDXW + CW + NF + NF*FW
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             commit_valid,
  input  logic [NF*FW-1:0] commit_fields,
  input  logic             flush,
  input  logic             nde_valid,
  input  logic [EVW-1:0]   nde_code,
  output logic             rec_valid,
  output logic             rec_is_event,
  output logic [IDXW-1:0]  rec_first,
  output logic [IDXW-1:0]  rec_last,
  output logic [CW-1:0]    rec_count,
  output logic [NF-1:0]    rec_mask,
  output logic [NF*FW-1:0] rec_data,
  output logic [EVW-1:0]   rec_evcode
);

  logic             close;
  logic [IDXW-1:0]  cl_first;
  logic [IDXW-1:0]  cl_last;
  logic [CW-1:0]    cl_count;
  logic [NF*FW-1:0] cl_fields;
  logic [IDXW-1:0]  cur_idx;
  logic [NF-1:0]    d_mask;
  logic [NF*FW-1:0] d_vals;
  logic [EW-1:0]    q_din;
  logic [EW-1:0]    q_dout;
  logic             q_empty;
  logic             q_full;
  logic             q_pop;
  out_sel_e         sel;

  ccz_window #(.NF(NF), .FW(FW), .IDXW(IDXW), .MAX_MERGE(MAX_MERGE)) u_win (
    .clk(clk), .rst(rst), .commit_valid(commit_valid), .commit_fields(commit_fields),
    .flush(flush), .close(close), .cl_first(cl_first), .cl_last(cl_last),
    .cl_count(cl_count), .cl_fields(cl_fields), .cur_idx(cur_idx)
  );

  ccz_diff #(.NF(NF), .FW(FW)) u_diff (
    .clk(clk), .rst(rst), .close(close), .new_fields(cl_fields),
    .mask(d_mask), .packed_vals(d_vals)
  );

  assign q_din = {cl_first, cl_last, cl_count, d_mask, d_vals};

  ccz_queue #(.W(EW), .DEPTH(QDEPTH)) u_q (
    .clk(clk), .rst(rst), .push(close), .din(q_din), .pop(q_pop),
    .dout(q_dout), .empty(q_empty), .full(q_full)
  );

  always_comb begin
    if (nde_valid)     sel = OUT_EVENT;
    else if (!q_empty) sel = OUT_QUEUE;
    else               sel = OUT_NONE;
  end

  assign q_pop = (sel == OUT_QUEUE);

  always_ff @(posedge clk) begin
    if (rst) begin
      rec_valid    <= 1'b0;
      rec_is_event <= 1'b0;
      rec_first    <= '0;
      rec_last     <= '0;
      rec_count    <= '0;
      rec_mask     <= '0;
      rec_data     <= '0;
      rec_evcode   <= '0;
    end else begin
      unique case (sel)
        OUT_EVENT: begin
          rec_valid    <= 1'b1;
          rec_is_event <= 1'b1;
          rec_first    <= cur_idx;
          rec_last     <= cur_idx;
          rec_count    <= '0;
          rec_mask     <= '0;
          rec_data     <= '0;
          rec_evcode   <= nde_code;
        end
        OUT_QUEUE: begin
          rec_valid    <= 1'b1;
          rec_is_event <= 1'b0;
          {rec_first, rec_last, rec_count, rec_mask, rec_data} <= q_dout;
          rec_evcode   <= '0;
        end
        default: begin
          rec_valid    <= 1'b0;
        end
      endcase
    end
  end

endmodule

// File: rtl/ccz_checker.sv
module ccz_checker #(
  parameter int NF        = 4,
  parameter int FW        = 16,
  parameter int IDXW      = 16,
  parameter int MAX_MERGE = 32,
  localparam int CW       = $clog2(MAX_MERGE + 1)
) (
  input logic             clk,
  input logic             rst,
  input logic             nde_valid,
  input logic             q_push,
  input logic             q_pop,
  input logic             q_full,
  input logic             rec_valid,
  input logic             rec_is_event,
  input logic [IDXW-1:0]  rec_first,
  input logic [IDXW-1:0]  rec_last,
  input logic [CW-1:0]    rec_count,
  input logic [NF-1:0]    rec_mask,
  input logic [NF*FW-1:0] rec_data
);

  logic            have_prev;
  logic [IDXW-1:0] prev_last;
  logic            tail_zero;

  always_comb begin
    int n;
    n         = $countones(rec_mask);
    tail_zero = 1'b1;
    for (int j = 0; j < NF; j++) begin
      if ((j >= n) && (rec_data[j*FW +: FW] != '0)) tail_zero = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      have_prev <= 1'b0;
      prev_last <= '0;
    end else if (rec_valid && !rec_is_event) begin
      have_prev <= 1'b1;
      prev_last <= rec_last;
    end
  end

  // R3: count bounded by window size
  p_count_bound_r3: assert property (@(posedge clk) disable iff (rst)
    (rec_valid && !rec_is_event) |-> (rec_count >= CW'(1) && rec_count <= CW'(MAX_MERGE)));

  // R2: index range matches count
  p_range_r2: assert property (@(posedge clk) disable iff (rst)
    (rec_valid && !rec_is_event) |-> (IDXW'(rec_last - rec_first + IDXW'(1)) == IDXW'(rec_count)));

  // R8: commit records are contiguous
  p_contiguous_r8: assert property (@(posedge clk) disable iff (rst)
    (rec_valid && !rec_is_event && have_prev) |-> (rec_first == IDXW'(prev_last + IDXW'(1))));

  // R6: unused slots are zero
  p_tail_zero_r6: assert property (@(posedge clk) disable iff (rst)
    (rec_valid && !rec_is_event) |-> tail_zero);

  // R7: event forwarded on the sampling edge
  p_event_prompt_r7: assert property (@(posedge clk) disable iff (rst)
    nde_valid |=> (rec_valid && rec_is_event));

  // R7: input rule, events never back to back
  p_event_spacing_r7: assert property (@(posedge clk) disable iff (rst)
    nde_valid |=> !nde_valid);

  // R8: closed-record queue never overflows
  p_no_overflow_r8: assert property (@(posedge clk) disable iff (rst)
    (q_push && q_full) |-> q_pop);

endmodule

bind commit_diff_compressor ccz_checker #(
  .NF(NF), .FW(FW), .IDXW(IDXW), .MAX_MERGE(MAX_MERGE)
) u_chk (
  .clk(clk), .rst(rst), .nde_valid(nde_valid), .q_push(close), .q_pop(q_pop),
  .q_full(q_full), .rec_valid(rec_valid), .rec_is_event(rec_is_event),
  .rec_first(rec_first), .rec_last(rec_last), .rec_count(rec_count),
  .rec_mask(rec_mask), .rec_data(rec_data)
);

// File: tb/commit_diff_compressor_test.sv
module commit_diff_compressor_test;

  localparam int CLK_PERIOD = 10;
  localparam int NF   = 4;
  localparam int FW   = 16;
  localparam int IDXW = 16;
  localparam int EVW  = 8;
  localparam int MAXM = 32;
  localparam int CW   = $clog2(MAXM + 1);

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             commit_valid = 1'b0;
  logic [NF*FW-1:0] commit_fields = '0;
  logic             flush = 1'b0;
  logic             nde_valid = 1'b0;
  logic [EVW-1:0]   nde_code = '0;
  logic             rec_valid;
  logic             rec_is_event;
  logic [IDXW-1:0]  rec_first;
  logic [IDXW-1:0]  rec_last;
  logic [CW-1:0]    rec_count;
  logic [NF-1:0]    rec_mask;
  logic [NF*FW-1:0] rec_data;
  logic [EVW-1:0]   rec_evcode;

  int n_checks = 0;
  int n_err    = 0;
  int b_idx    = 0;
  logic [NF*FW-1:0] b_ref = '0;
  bit               b_ref_valid = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  commit_diff_compressor #(.NF(NF), .FW(FW), .IDXW(IDXW), .EVW(EVW), .MAX_MERGE(MAXM)) uut (
    .clk(clk), .rst(rst), .commit_valid(commit_valid), .commit_fields(commit_fields),
    .flush(flush), .nde_valid(nde_valid), .nde_code(nde_code),
    .rec_valid(rec_valid), .rec_is_event(rec_is_event), .rec_first(rec_first),
    .rec_last(rec_last), .rec_count(rec_count), .rec_mask(rec_mask),
    .rec_data(rec_data), .rec_evcode(rec_evcode)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] got, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic step(input logic cv, input logic [NF*FW-1:0] fv, input logic fl,
                      input logic ev, input logic [EVW-1:0] code);
    @(negedge clk);
    commit_valid  = cv;
    commit_fields = fv;
    flush         = fl;
    nde_valid     = ev;
    nde_code      = code;
    @(posedge clk);
    #1;
    if (cv) b_idx++;
  endtask

  task automatic idle();
    step(1'b0, '0, 1'b0, 1'b0, '0);
  endtask

  function automatic logic [NF*FW-1:0] mk(input int base);
    logic [NF*FW-1:0] v;
    for (int i = 0; i < NF; i++) v[i*FW +: FW] = FW'(base + i);
    return v;
  endfunction

  task automatic expect_none(input string tag);
    chk(rec_valid == 1'b0, tag, 64'(rec_valid), 64'd0);
  endtask

  task automatic expect_event(input int seq, input logic [EVW-1:0] code, input string tag);
    chk(rec_valid && rec_is_event, {tag, " event flag"}, 64'({rec_valid, rec_is_event}), 64'd3);
    chk(rec_first == IDXW'(seq) && rec_last == IDXW'(seq), {tag, " seq"}, 64'(rec_first), 64'(seq));
    chk(rec_evcode == code, {tag, " code"}, 64'(rec_evcode), 64'(code));
  endtask

  task automatic expect_commit(input int first, input int last, input int cnt,
                               input logic [NF*FW-1:0] fv, input string tag);
    logic [NF-1:0]    m;
    logic [NF*FW-1:0] d;
    int slot;
    slot = 0;
    d    = '0;
    for (int i = 0; i < NF; i++) begin
      m[i] = !b_ref_valid || (fv[i*FW +: FW] != b_ref[i*FW +: FW]);
      if (m[i]) begin
        d[slot*FW +: FW] = fv[i*FW +: FW];
        slot++;
      end
    end
    b_ref       = fv;
    b_ref_valid = 1'b1;
    chk(rec_valid && !rec_is_event, {tag, " commit flag"}, 64'({rec_valid, rec_is_event}), 64'd2);
    chk(rec_first == IDXW'(first), {tag, " first"}, 64'(rec_first), 64'(first));
    chk(rec_last == IDXW'(last), {tag, " last"}, 64'(rec_last), 64'(last));
    chk(rec_count == CW'(cnt), {tag, " count"}, 64'(rec_count), 64'(cnt));
    chk(rec_mask == m, {tag, " mask"}, 64'(rec_mask), 64'(m));
    chk(rec_data == d, {tag, " data"}, 64'(rec_data), 64'(d));
  endtask

  // R1
  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    expect_none("R1 in reset");
    @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < 3; i++) begin
      idle();
      expect_none("R1 after reset");
    end
  endtask

  // R2 R5 R6 R8: first record carries full state
  task automatic t_first();
    step(1'b1, mk(16'h10), 1'b0, 1'b0, '0);
    expect_none("R2 open");
    step(1'b1, mk(16'h20), 1'b0, 1'b0, '0);
    step(1'b1, mk(16'h30), 1'b1, 1'b0, '0);
    expect_none("R8 close cycle");
    idle();
    expect_commit(0, 2, 3, mk(16'h30), "R5 first record");
  endtask

  // R5 R6: sparse change packing
  task automatic t_diff();
    logic [NF*FW-1:0] e;
    e = mk(16'h30);
    e[1*FW +: FW] = 16'hBEEF;
    e[3*FW +: FW] = 16'hCAFE;
    step(1'b1, mk(16'h30), 1'b0, 1'b0, '0);
    step(1'b1, e, 1'b1, 1'b0, '0);
    idle();
    expect_commit(3, 4, 2, e, "R6 sparse");
  endtask

  // R4: flush without commit, then flush into empty window
  task automatic t_flush();
    logic [NF*FW-1:0] e;
    e = b_ref;
    step(1'b1, e, 1'b0, 1'b0, '0);
    idle();
    expect_none("R9 idle");
    step(1'b0, '0, 1'b1, 1'b0, '0);
    idle();
    expect_commit(5, 5, 1, e, "R4 lone flush");
    step(1'b0, '0, 1'b1, 1'b0, '0);
    expect_none("R4 empty flush a");
    idle();
    expect_none("R4 empty flush b");
  endtask

  // R9: idle gaps leave window intact
  task automatic t_gaps();
    step(1'b1, mk(16'h50), 1'b0, 1'b0, '0);
    for (int i = 0; i < 3; i++) begin
      idle();
      expect_none("R9 gap");
    end
    step(1'b1, mk(16'h60), 1'b1, 1'b0, '0);
    idle();
    expect_commit(6, 7, 2, mk(16'h60), "R9 gaps");
  endtask

  // R7: event inside a window
  task automatic t_event_mid();
    int s;
    step(1'b1, mk(16'h70), 1'b0, 1'b0, '0);
    step(1'b1, mk(16'h70), 1'b0, 1'b0, '0);
    s = b_idx;
    step(1'b1, mk(16'h71), 1'b0, 1'b1, 8'h5A);
    expect_event(s, 8'h5A, "R7 mid window");
    step(1'b1, mk(16'h72), 1'b1, 1'b0, '0);
    expect_none("R7 no early record");
    idle();
    expect_commit(8, 11, 4, mk(16'h72), "R7 window kept");
    s = b_idx;
    step(1'b0, '0, 1'b0, 1'b1, 8'h11);
    expect_event(s, 8'h11, "R7 idle event");
    idle();
    expect_none("R7 no window opened");
  endtask

  // R8: event in the closing cycle goes first
  task automatic t_event_close();
    int s;
    step(1'b1, mk(16'h80), 1'b0, 1'b0, '0);
    s = b_idx;
    step(1'b1, mk(16'h90), 1'b1, 1'b1, 8'hA5);
    expect_event(s, 8'hA5, "R8 event first");
    idle();
    expect_commit(12, 13, 2, mk(16'h90), "R8 commit after");
  endtask

  // R3: window closes at MAX_MERGE
  task automatic t_max();
    for (int i = 0; i < MAXM; i++) begin
      step(1'b1, mk(16'hA0 + (i % 3)), 1'b0, 1'b0, '0);
      if (i < MAXM - 1) expect_none("R3 filling");
    end
    idle();
    expect_commit(14, 14 + MAXM - 1, MAXM, mk(16'hA0 + ((MAXM - 1) % 3)), "R3 full");
    step(1'b1, mk(16'hB0), 1'b1, 1'b0, '0);
    idle();
    expect_commit(14 + MAXM, 14 + MAXM, 1, mk(16'hB0), "R3 new window");
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_first();
        t_diff();
        t_flush();
        t_gaps();
        t_event_mid();
        t_event_close();
        t_max();
      end
      begin
        #(CLK_PERIOD * 200000);
        n_checks++;
        n_err++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end

endmodule